// File: doc/BRIEF.md
# Sliding-Window Exponent Partitioner

This block walks an exponent from its top bit to its bottom bit, one bit per clock, and cuts it into windows for a sliding-window exponentiation engine. A window is either a run of zeros of any length or a nonzero window. A nonzero window always starts and ends with a 1, holds at most `K` bits, and is closed early when `Q` zeros in a row follow it. Zeros that are cut off the end of a nonzero window become part of the zero window that follows it. As a result, the window lengths always add up to the exponent width `M`.

The user loads the exponent in parallel with a one-cycle `start` pulse. Windows then come out as records over a valid/ready handshake. Each record holds a type bit, a length and a right-justified value. If the exponent has zeros above its highest set bit, those zeros form the first record, and that record is marked so the consumer can skip it. When the last record has been taken, `done` is raised. Two counters report how many zero windows and how many nonzero windows have been taken so far. The parameter `K` must be at least 2.

Top module: `exp_window_splitter`

## Requirements
- R1: After reset, `rec_valid` and `done` are 0 and both window counters read 0.
- R2: Records come out from the most significant end to the least significant end. Their lengths add up to `M`, and each record's value is the exponent bits it covers.
- R3: A zero window has `rec_nz`=0, `rec_val`=0 and a length of at least 1. It covers a complete run of zeros, from the bit after a 1 (or from the top bit) up to the next 1 (or the end of the exponent).
- R4: A nonzero window has `rec_nz`=1. Its value, right-justified in `rec_val`, is always odd.
- R5: `Q` zeros in a row inside an open nonzero window close that window. The window is trimmed back to its last 1.
- R6: A nonzero window is never longer than `K` bits. When it reaches `K` bits it is cut, with its trailing zeros trimmed. The next bit then starts a new window.
- R7: `rec_lead`=1 only on the first record of a run, and only when that record is a zero window. An all-zero exponent gives exactly one zero window of length `M`, and that window is marked.
- R8: While `rec_valid`=1 and `rec_ready`=0, the record stays valid and its fields do not change. No record is lost or repeated.
- R9: `done` rises only after the last record has been accepted, and `rec_valid` is 0 while `done`=1. At that point `zero_cnt` and `nz_cnt` equal the numbers of zero and nonzero records taken.
- R10: A `start` pulse that arrives while a run is in progress is ignored. The run in progress finishes unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Load `exp_in` and begin a run (taken only when idle) |
| exp_in | input | M | Exponent to partition |
| rec_ready | input | 1 | Consumer accepts the current record |
| rec_valid | output | 1 | A record is presented |
| rec_nz | output | 1 | 1 = nonzero window, 0 = zero window |
| rec_lead | output | 1 | Record is the leading zero window |
| rec_len | output | $clog2(M+1) | Window length in bits |
| rec_val | output | K | Window bits, right-justified (0 for zero windows) |
| done | output | 1 | Run complete, all records taken |
| zero_cnt | output | $clog2(M+1) | Zero windows accepted in this run |
| nz_cnt | output | $clog2(M+1) | Nonzero windows accepted in this run |

## Verification
A wrong run or trailing-zero count in the scanner shows up in the next emitted record as a wrong length or an even value. It also shifts every later boundary, so the lengths no longer add up to `M` when `done` rises. A record slot that is overwritten or dropped under backpressure shows up within one stalled cycle as a changed field, or as a record missing from the expected sequence. The bench runs every exponent of a small configuration, once with `rec_ready` held high and once with `rec_ready` toggling, and compares each record against a window list it builds from the rules above.

// File: rtl/exp_window_splitter.sv
module exp_window_splitter #(
  parameter int M = 16,
  parameter int K = 4,
  parameter int Q = 2
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       start,
  input  logic [M-1:0]               exp_in,
  input  logic                       rec_ready,
  output logic                       rec_valid,
  output logic                       rec_nz,
  output logic                       rec_lead,
  output logic [$clog2(M+1)-1:0]     rec_len,
  output logic [K-1:0]               rec_val,
  output logic                       done,
  output logic [$clog2(M+1)-1:0]     zero_cnt,
  output logic [$clog2(M+1)-1:0]     nz_cnt
);
  localparam int LW = $clog2(M+1);

  typedef enum logic [1:0] {S_IDLE, S_ZW, S_NZ, S_FIN} st_t;
  st_t st;

  logic [M-1:0]  sh;
  logic [LW-1:0] rem, zl, nl, tz;
  logic [K-1:0]  win;
  logic          first;

  wire          slot_free = !rec_valid || rec_ready;
  wire          adv       = (st == S_ZW || st == S_NZ) && slot_free;
  wire          b         = sh[M-1];
  wire          have_bit  = (rem != '0);
  wire [K-1:0]  nwin      = {win[K-2:0], b};
  wire [LW-1:0] nn        = nl + LW'(1);
  wire [LW-1:0] ntz       = b ? '0 : tz + LW'(1);
  wire          cut       = (!b && ntz == LW'(Q)) || nn == LW'(K);

  logic          e_v, e_nz;
  logic [LW-1:0] e_len;
  logic [K-1:0]  e_val;

  always_comb begin
    e_v = 1'b0; e_nz = 1'b0; e_len = '0; e_val = '0;
    if (adv) begin
      if (have_bit) begin
        if (st == S_ZW && b && zl != '0) begin
          e_v = 1'b1; e_len = zl;
        end else if (st == S_NZ && cut) begin
          e_v = 1'b1; e_nz = 1'b1; e_len = nn - ntz; e_val = nwin >> ntz;
        end
      end else if (st == S_NZ) begin
        e_v = 1'b1; e_nz = 1'b1; e_len = nl - tz; e_val = win >> tz;
      end else if (zl != '0) begin
        e_v = 1'b1; e_len = zl;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; sh <= '0; rem <= '0; zl <= '0; nl <= '0; tz <= '0;
      win <= '0; first <= 1'b0; done <= 1'b0;
      rec_valid <= 1'b0; rec_nz <= 1'b0; rec_lead <= 1'b0;
      rec_len <= '0; rec_val <= '0; zero_cnt <= '0; nz_cnt <= '0;
    end else begin
      if (rec_valid && rec_ready) begin
        rec_valid <= 1'b0;
        if (rec_nz) nz_cnt <= nz_cnt + LW'(1);
        else        zero_cnt <= zero_cnt + LW'(1);
      end
      if (e_v) begin
        rec_valid <= 1'b1;
        rec_nz    <= e_nz;
        rec_lead  <= first && !e_nz;
        rec_len   <= e_len;
        rec_val   <= e_val;
        first     <= 1'b0;
      end
      case (st)
        S_IDLE: if (start) begin
          st <= S_ZW; sh <= exp_in; rem <= LW'(M); zl <= '0;
          first <= 1'b1; done <= 1'b0; zero_cnt <= '0; nz_cnt <= '0;
        end
        S_ZW: if (adv) begin
          if (have_bit) begin
            sh <= sh << 1; rem <= rem - LW'(1);
            if (b) begin
              st <= S_NZ; win <= K'(1); nl <= LW'(1); tz <= '0; zl <= '0;
            end else zl <= zl + LW'(1);
          end else st <= S_FIN;
        end
        S_NZ: if (adv) begin
          if (have_bit) begin
            sh <= sh << 1; rem <= rem - LW'(1);
            if (cut) begin
              st <= S_ZW; zl <= ntz;
            end else begin
              win <= nwin; nl <= nn; tz <= ntz;
            end
          end else begin
            st <= S_ZW; zl <= tz;
          end
        end
        S_FIN: if (slot_free) begin
          st <= S_IDLE; done <= 1'b1;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  assert_stall_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    rec_valid && !rec_ready |=> rec_valid && $stable(rec_nz) && $stable(rec_len)
                                && $stable(rec_val) && $stable(rec_lead));
  assert_odd_value_R4: assert property (@(posedge clk) disable iff (!rst_n)
    rec_valid && rec_nz |-> rec_val[0]);
  assert_len_cap_R6: assert property (@(posedge clk) disable iff (!rst_n)
    rec_valid && rec_nz |-> rec_len <= LW'(K) && rec_len != '0);
  assert_zero_win_R3: assert property (@(posedge clk) disable iff (!rst_n)
    rec_valid && !rec_nz |-> rec_val == '0 && rec_len != '0);
  assert_lead_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
    rec_valid && rec_lead |-> !rec_nz);
  assert_done_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !rec_valid);
endmodule

// File: tb/exp_window_splitter_tb_top.sv
module exp_window_splitter_tb_top;
  localparam int M = 10;
  localparam int K = 4;
  localparam int Q = 2;
  localparam int LW = $clog2(M+1);

  logic clk = 0, rst_n = 0, start = 0, rec_ready = 0;
  logic [M-1:0] exp_in = '0;
  logic rec_valid, rec_nz, rec_lead, done;
  logic [LW-1:0] rec_len, zero_cnt, nz_cnt;
  logic [K-1:0] rec_val;

  exp_window_splitter #(.M(M), .K(K), .Q(Q)) dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .exp_in(exp_in),
    .rec_ready(rec_ready), .rec_valid(rec_valid), .rec_nz(rec_nz),
    .rec_lead(rec_lead), .rec_len(rec_len), .rec_val(rec_val), .done(done),
    .zero_cnt(zero_cnt), .nz_cnt(nz_cnt));

  always #5 clk = ~clk;

  int tests = 0, fails = 0;
  int ex_n, ex_zc, ex_nzc;
  int ex_nz[M], ex_len[M], ex_val[M], ex_lead[M];

  task automatic chk(input bit ok, input string tag, input int act, input int expv);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s exp_in=%b actual=%0d expected=%0d", tag, exp_in, act, expv);
    end
  endtask

  task automatic add(input int nz, input int lead, input int len, input int val);
    ex_nz[ex_n] = nz; ex_lead[ex_n] = lead; ex_len[ex_n] = len; ex_val[ex_n] = val;
    ex_n++;
    if (nz != 0) ex_nzc++; else ex_zc++;
  endtask

  task automatic build(input logic [M-1:0] e);
    int p, r, last, zr, v;
    bit fst;
    ex_n = 0; ex_zc = 0; ex_nzc = 0; p = M-1; fst = 1;
    while (p >= 0) begin
      if (!e[p]) begin
        r = 0;
        while (p >= 0 && !e[p]) begin r++; p--; end
        add(0, fst, r, 0);
      end else begin
        last = 0; zr = 0;
        for (int j = 0; j < K && p-j >= 0; j++) begin
          if (e[p-j]) begin last = j; zr = 0; end
          else begin zr++; if (zr == Q) break; end
        end
        v = 0;
        for (int j = 0; j <= last; j++) v = (v << 1) | int'(e[p-j]);
        add(1, 0, last+1, v);
        p = p - (last+1);
      end
      fst = 0;
    end
  endtask

  task automatic run(input logic [M-1:0] e, input int mode, input bit inj);
    int got, guard, sum;
    bit stalled;
    logic s_nz, s_lead;
    logic [LW-1:0] s_len;
    logic [K-1:0] s_val;
    build(e);
    @(negedge clk); exp_in = e; start = 1;
    @(negedge clk); start = 0;
    got = 0; guard = 0; sum = 0; stalled = 0;
    s_nz = 0; s_lead = 0; s_len = '0; s_val = '0;
    while (!done && guard < 500) begin
      rec_ready = (mode == 0) ? 1'b1 : (((guard*5 + int'(e)) % 3) != 0);
      if (inj && guard == 3) begin start = 1; exp_in = ~e; end
      else begin start = 0; exp_in = e; end
      #1;
      if (stalled) begin
        chk(rec_valid && rec_nz == s_nz && rec_len == s_len && rec_val == s_val
            && rec_lead == s_lead, "R8 held record changed", int'(rec_len), int'(s_len));
      end
      stalled = 0;
      if (rec_valid) begin
        if (!rec_ready) begin
          stalled = 1; s_nz = rec_nz; s_len = rec_len; s_val = rec_val; s_lead = rec_lead;
        end else if (got >= ex_n) begin
          chk(0, "R2 extra record", got+1, ex_n);
        end else begin
          chk(int'(rec_nz) == ex_nz[got], "R5 window type", int'(rec_nz), ex_nz[got]);
          chk(int'(rec_len) == ex_len[got], ex_nz[got] != 0 ? "R6 nonzero length" : "R3 zero length",
              int'(rec_len), ex_len[got]);
          chk(int'(rec_val) == ex_val[got], "R4 window value", int'(rec_val), ex_val[got]);
          chk(int'(rec_lead) == ex_lead[got], "R7 lead flag", int'(rec_lead), ex_lead[got]);
          if (rec_nz) begin
            chk(rec_val[0] == 1'b1, "R4 odd value", int'(rec_val), 1);
            chk(int'(rec_len) <= K, "R6 length cap", int'(rec_len), K);
          end
          sum += int'(rec_len);
          got++;
        end
      end
      @(negedge clk); guard++;
    end
    start = 0; exp_in = e;
    #1;
    chk(done == 1'b1, "R9 done reached", int'(done), 1);
    chk(!rec_valid, "R9 valid low at done", int'(rec_valid), 0);
    chk(got == ex_n, inj ? "R10 record count after ignored start" : "R9 record count", got, ex_n);
    chk(sum == M, "R2 length sum", sum, M);
    chk(int'(zero_cnt) == ex_zc, "R9 zero counter", int'(zero_cnt), ex_zc);
    chk(int'(nz_cnt) == ex_nzc, "R9 nonzero counter", int'(nz_cnt), ex_nzc);
  endtask

  initial begin
    #1900000;
    fails++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    #1;
    chk(!rec_valid, "R1 valid after reset", int'(rec_valid), 0);
    chk(!done, "R1 done after reset", int'(done), 0);
    chk(zero_cnt == '0 && nz_cnt == '0, "R1 counters after reset", int'(zero_cnt) + int'(nz_cnt), 0);
    rst_n = 1;
    run('0, 0, 0);
    chk(ex_n == 1 && ex_len[0] == M && ex_lead[0] == 1, "R7 all-zero model", ex_n, 1);
    for (int e = 0; e < (1 << M); e++) run(M'(e), 0, 0);
    for (int e = 0; e < (1 << M); e++) run(M'(e), 1, (e % 5) == 0);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule